// File: doc/BRIEF.md
# Translation Fault Capture Registers

This block holds the record of a data translation fault for software to examine. When the fault-detection logic raises a strobe, the block stores three values. The first is the faulting virtual address. The second is a status word that packs the instruction opcode, the destination register number and a set of fault flags. The third is a formatted page-table-entry address, built from a page-table base and the virtual page number. Fault detection itself happens outside this block.

After a capture the registers are locked, and later faults leave them untouched. The lock clears when software reads the address register, which it signals with a read strobe. A fault raised by a misspeculated instruction never touches the registers or the lock. The three registers and the lock flag are visible as outputs.

Top module: `mmfc_top`

## Requirements
- R1: A strobe `flt_stb` with `flt_spec` low while `lock_o` is low stores `flt_va` into `va_o` and sets `lock_o`, both visible after the next rising clock edge.
- R2: On the same capture, `stat_o` receives the opcode in bits 16:11, the destination register number in bits 10:6 and the six flag bits in bits 5:0. The flags are, from bit 0 upward: write, access violation, fault-on-read, fault-on-write, TLB miss and bad address.
- R3: On the same capture, `form_o` receives `ptb_base` bitwise ORed with the virtual page number (`flt_va >> PAGE_SHIFT`, with PAGE_SHIFT = 13 by default) shifted left by 3.
- R4: While `lock_o` is high, a strobe changes none of `va_o`, `stat_o`, `form_o`.
- R5: A strobe with `flt_spec` high changes no register and does not set `lock_o`.
- R6: A pulse of `va_rd` while locked clears `lock_o` at the next rising edge, so a fault in the following cycle is captured. A fault raised in the same cycle as that read is still dropped.
- R7: Reset (`rst_n` low, asynchronous) clears `va_o`, `stat_o`, `form_o` and `lock_o`.
- R8: When unlocked, a capture and a `va_rd` in the same cycle leave the block locked with the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_stb | input | 1 | Fault strobe, one cycle per fault |
| flt_spec | input | 1 | Fault belongs to a misspeculated instruction |
| flt_va | input | VA_W | Faulting virtual address |
| flt_opc | input | 6 | Opcode of the faulting instruction |
| flt_rn | input | 5 | Destination register number |
| flt_flg | input | 6 | Fault flag bits |
| ptb_base | input | PTB_W | Page-table base value |
| va_rd | input | 1 | Software read of the address register |
| va_o | output | VA_W | Captured virtual address |
| stat_o | output | 17 | Captured status word |
| form_o | output | PTB_W | Captured formatted PTE address |
| lock_o | output | 1 | Registers are locked |

## Verification
Every result is a single register stage away from its stimulus. A capture, a lock set or a lock clear shows on the outputs after the first rising edge that samples the strobe, and on no edge before it. The bench drives inputs on the falling edge, holds them through one rising edge, and reads the outputs on the next falling edge, so it always compares the value due exactly one edge later. The ignore cases (locked, misspeculated, a fault in the same cycle as the read) are checked on the outputs after that same edge, before any other stimulus is applied.

// File: rtl/mmfc_pkg.sv
package mmfc_pkg;
  localparam int OPC_W  = 6;
  localparam int RN_W   = 5;
  localparam int FLG_W  = 6;
  localparam int STAT_W = OPC_W + RN_W + FLG_W;
  localparam int PTE_SH = 3;

  function automatic logic [STAT_W-1:0] pack_stat(
    input logic [OPC_W-1:0] opc,
    input logic [RN_W-1:0]  rn,
    input logic [FLG_W-1:0] flg);
    return {opc, rn, flg};
  endfunction
endpackage

// File: rtl/mmfc_fmt.sv
module mmfc_fmt
  import mmfc_pkg::*;
#(
  parameter int VPN_W = 30,
  parameter int PTB_W = 64
) (
  input  logic [VPN_W-1:0]  vpn,
  input  logic [OPC_W-1:0]  opc,
  input  logic [RN_W-1:0]   rn,
  input  logic [FLG_W-1:0]  flg,
  input  logic [PTB_W-1:0]  ptb,
  output logic [STAT_W-1:0] stat,
  output logic [PTB_W-1:0]  form
);
  localparam int PAD_W = PTB_W - VPN_W - PTE_SH;

  logic [PTB_W-1:0] vpn_sh;

  always_comb begin
    vpn_sh = {{PAD_W{1'b0}}, vpn, {PTE_SH{1'b0}}};
    form   = ptb | vpn_sh;
    stat   = pack_stat(opc, rn, flg);
  end
endmodule

// File: rtl/mmfc_lock.sv
module mmfc_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic spec,
  input  logic rd,
  output logic cap,
  output logic lock
);
  logic lock_d, lock_q;

  always_comb begin
    cap    = stb & ~spec & ~lock_q;
    lock_d = lock_q;
    if (cap)     lock_d = 1'b1;
    else if (rd) lock_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_d;
  end

  assign lock = lock_q;
endmodule

// File: rtl/mmfc_reg.sv
module mmfc_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt, cur;

  always_comb nxt = en ? d : cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else        cur <= nxt;
  end

  assign q = cur;
endmodule

// File: rtl/mmfc_top.sv
module mmfc_top
  import mmfc_pkg::*;
#(
  parameter int VA_W       = 43,
  parameter int PAGE_SHIFT = 13,
  parameter int PTB_W      = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flt_stb,
  input  logic              flt_spec,
  input  logic [VA_W-1:0]   flt_va,
  input  logic [OPC_W-1:0]  flt_opc,
  input  logic [RN_W-1:0]   flt_rn,
  input  logic [FLG_W-1:0]  flt_flg,
  input  logic [PTB_W-1:0]  ptb_base,
  input  logic              va_rd,
  output logic [VA_W-1:0]   va_o,
  output logic [STAT_W-1:0] stat_o,
  output logic [PTB_W-1:0]  form_o,
  output logic              lock_o
);
  localparam int VPN_W = VA_W - PAGE_SHIFT;

  logic              cap;
  logic [STAT_W-1:0] stat_n;
  logic [PTB_W-1:0]  form_n;

  mmfc_lock u_lock (
    .clk (clk), .rst_n(rst_n), .stb(flt_stb), .spec(flt_spec),
    .rd  (va_rd), .cap(cap), .lock(lock_o)
  );

  mmfc_fmt #(.VPN_W(VPN_W), .PTB_W(PTB_W)) u_fmt (
    .vpn (flt_va[VA_W-1:PAGE_SHIFT]), .opc(flt_opc), .rn(flt_rn),
    .flg (flt_flg), .ptb(ptb_base), .stat(stat_n), .form(form_n)
  );

  mmfc_reg #(.W(VA_W)) u_va (
    .clk(clk), .rst_n(rst_n), .en(cap), .d(flt_va), .q(va_o)
  );

  mmfc_reg #(.W(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .en(cap), .d(stat_n), .q(stat_o)
  );

  mmfc_reg #(.W(PTB_W)) u_form (
    .clk(clk), .rst_n(rst_n), .en(cap), .d(form_n), .q(form_o)
  );
endmodule

// File: rtl/mmfc_chk.sv
module mmfc_chk
  import mmfc_pkg::*;
#(
  parameter int VA_W  = 43,
  parameter int PTB_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flt_stb,
  input logic              flt_spec,
  input logic [VA_W-1:0]   flt_va,
  input logic [OPC_W-1:0]  flt_opc,
  input logic [RN_W-1:0]   flt_rn,
  input logic [FLG_W-1:0]  flt_flg,
  input logic              va_rd,
  input logic [VA_W-1:0]   va_o,
  input logic [STAT_W-1:0] stat_o,
  input logic [PTB_W-1:0]  form_o,
  input logic              lock_o
);
  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_stb && !flt_spec && !lock_o) |=> (lock_o && va_o == $past(flt_va)));

  p_stat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_stb && !flt_spec && !lock_o) |=>
      (stat_o[16:11] == $past(flt_opc) && stat_o[10:6] == $past(flt_rn)
       && stat_o[5:0] == $past(flt_flg)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |=> ($stable(va_o) && $stable(stat_o) && $stable(form_o)));

  p_spec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_o && flt_spec && !va_rd) |=> (!lock_o && $stable(va_o)));

  p_unlock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && va_rd) |=> !lock_o);

  p_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_o && flt_stb && !flt_spec && va_rd) |=> lock_o);
endmodule

bind mmfc_top mmfc_chk #(.VA_W(VA_W), .PTB_W(PTB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flt_stb(flt_stb), .flt_spec(flt_spec),
  .flt_va(flt_va), .flt_opc(flt_opc), .flt_rn(flt_rn), .flt_flg(flt_flg),
  .va_rd(va_rd), .va_o(va_o), .stat_o(stat_o), .form_o(form_o),
  .lock_o(lock_o)
);

// File: tb/sim_mmfc_top.sv
module sim_mmfc_top;
  localparam int CLK_P = 10;
  localparam int VA_W  = 43;
  localparam int PTB_W = 64;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              flt_stb, flt_spec, va_rd;
  logic [VA_W-1:0]   flt_va;
  logic [5:0]        flt_opc;
  logic [4:0]        flt_rn;
  logic [5:0]        flt_flg;
  logic [PTB_W-1:0]  ptb_base;
  logic [VA_W-1:0]   va_o;
  logic [16:0]       stat_o;
  logic [PTB_W-1:0]  form_o;
  logic              lock_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mmfc_top u0 (
    .clk(clk), .rst_n(rst_n), .flt_stb(flt_stb), .flt_spec(flt_spec),
    .flt_va(flt_va), .flt_opc(flt_opc), .flt_rn(flt_rn), .flt_flg(flt_flg),
    .ptb_base(ptb_base), .va_rd(va_rd), .va_o(va_o), .stat_o(stat_o),
    .form_o(form_o), .lock_o(lock_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_form(input logic [VA_W-1:0] va, input logic [63:0] ptb);
    logic [63:0] vpn;
    vpn = 64'(va >> 13);
    return ptb | (vpn << 3);
  endfunction

  // one cycle of stimulus, then outputs read on the following falling edge
  task automatic step(input logic stb, input logic spec, input logic rd,
                      input logic [VA_W-1:0] va, input logic [5:0] opc,
                      input logic [4:0] rn, input logic [5:0] flg,
                      input logic [63:0] ptb);
    flt_stb = stb; flt_spec = spec; va_rd = rd;
    flt_va = va; flt_opc = opc; flt_rn = rn; flt_flg = flg; ptb_base = ptb;
    @(negedge clk);
    flt_stb = 1'b0; flt_spec = 1'b0; va_rd = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    step(1'b0, 1'b0, 1'b0, '0, '0, '0, '0, '0);
    step(1'b0, 1'b0, 1'b0, '0, '0, '0, '0, '0);
    chk("R7 va",   64'(va_o),   64'd0);
    chk("R7 stat", 64'(stat_o), 64'd0);
    chk("R7 form", form_o,      64'd0);
    chk("R7 lock", 64'(lock_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_capture(input logic [VA_W-1:0] va, input logic [5:0] opc,
                           input logic [4:0] rn, input logic [5:0] flg,
                           input logic [63:0] ptb);
    step(1'b1, 1'b0, 1'b0, va, opc, rn, flg, ptb);
    chk("R1 va",   64'(va_o), 64'(va));
    chk("R1 lock", 64'(lock_o), 64'd1);
    chk("R2 stat", 64'(stat_o), 64'({opc, rn, flg}));
    chk("R3 form", form_o, exp_form(va, ptb));
  endtask

  task automatic t_unlock;
    step(1'b0, 1'b0, 1'b1, '0, '0, '0, '0, '0);
    chk("R6 lock cleared", 64'(lock_o), 64'd0);
  endtask

  task automatic t_locked_ignore(input logic [VA_W-1:0] keep_va, input logic [16:0] keep_st,
                                 input logic [63:0] keep_fm);
    step(1'b1, 1'b0, 1'b0, 43'h1111_2222_333, 6'h3f, 5'h1f, 6'h3f, 64'hffff_0000_0000_0000);
    chk("R4 va held",   64'(va_o),   64'(keep_va));
    chk("R4 stat held", 64'(stat_o), 64'(keep_st));
    chk("R4 form held", form_o,      keep_fm);
    chk("R4 lock held", 64'(lock_o), 64'd1);
  endtask

  task automatic t_spec(input logic [VA_W-1:0] keep_va);
    step(1'b1, 1'b1, 1'b0, 43'h0ABC_DEF0_123, 6'h11, 5'h02, 6'h01, 64'h10);
    chk("R5 va unchanged", 64'(va_o), 64'(keep_va));
    chk("R5 no lock",      64'(lock_o), 64'd0);
  endtask

  task automatic t_read_with_fault(input logic [VA_W-1:0] keep_va);
    step(1'b1, 1'b0, 1'b1, 43'h0123_4567_89A, 6'h05, 5'h06, 6'h07, 64'h0);
    chk("R6 same-cycle fault dropped", 64'(va_o), 64'(keep_va));
    chk("R6 lock cleared", 64'(lock_o), 64'd0);
  endtask

  task automatic t_both_unlocked(input logic [VA_W-1:0] va);
    step(1'b1, 1'b0, 1'b1, va, 6'h2a, 5'h15, 6'h2a, 64'h0000_0ff0_0000_0000);
    chk("R8 lock set", 64'(lock_o), 64'd1);
    chk("R8 va",       64'(va_o),   64'(va));
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; flt_stb = 1'b0; flt_spec = 1'b0; va_rd = 1'b0;
    flt_va = '0; flt_opc = '0; flt_rn = '0; flt_flg = '0; ptb_base = '0;
    @(negedge clk);
    t_reset();
    t_spec(43'd0);
    t_capture(43'h7AB_CDEF_0123, 6'h23, 5'h0b, 6'b100001, 64'h0000_0ff0_0000_0000);
    t_locked_ignore(43'h7AB_CDEF_0123, {6'h23, 5'h0b, 6'b100001},
                    exp_form(43'h7AB_CDEF_0123, 64'h0000_0ff0_0000_0000));
    t_read_with_fault(43'h7AB_CDEF_0123);
    t_capture(43'h000_0000_1FFF, 6'h3f, 5'h00, 6'b010110, 64'hffff_fff0_0000_0000);
    t_unlock();
    t_capture(43'h400_0000_2000, 6'h00, 5'h1f, 6'b001001, 64'h0000_0000_0000_0005);
    t_unlock();
    t_spec(43'h400_0000_2000);
    t_both_unlocked(43'h155_5555_5555);
    t_reset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule